// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block brings up three board supplies in a fixed order and produces the supervisory signals that go with them. It watches four comparator flags: the 3.3 V input above 3.0 V, the 1.8 V core rail above 1.7 V, the core rail above 1.71 V, and the 2.5 V I/O rail above 2.375 V. It drives the enable of the 1.8 V regulator, the enable of the 2.5 V converter, an active-low CPU reset and a power-good output. The 1.7 V flag is used only during bring-up, and the 1.71 V flag is used only for fault checks.

Once the I/O rail is valid, the block asserts power-good and starts an external delay timer for the 50 ms settle period, using a start/done handshake. When the timer reports done, the CPU reset is released and power-up is complete. If any rail drops while power-good is high, the block shuts down in order. It clears power-good and asserts the CPU reset, removes both rail enables on the next cycle, and then stays stopped until reset. It never retries on its own.

Every comparator flag passes through a synchronizer chain before the state machine uses it. All outputs are registered.

Top module: `power_seq_ctrl`

## Requirements
- R1: While rst_ni is low, every output is at its safe value, whatever the inputs: both enables low, cpu_rst_no low, pwr_good_o low and tmr_start_o low.
- R2: After reset, no output changes until in33_ok_i is seen high. Then core_ldo_en_o rises, and cpu_rst_no stays low.
- R3: io_conv_en_o rises only after core_up_ok_i is seen high while the core regulator is enabled.
- R4: When io_ok_i is seen high with both rails enabled, pwr_good_o and tmr_start_o rise together. tmr_start_o stays high only during the settle wait.
- R5: In the settle wait, tmr_done_i high on a clock edge releases cpu_rst_no (drives it high) and drops tmr_start_o at that same edge. In every other state tmr_done_i has no effect.
- R6: While pwr_good_o is high, a low in33_ok_i, io_ok_i or core_hold_ok_i is a fault. On the edge where the fault is seen, pwr_good_o falls and cpu_rst_no goes low, while both enables stay high for one more cycle.
- R7: One cycle after R6, both enables go low. All outputs then stay low until the next reset, whatever the inputs do.
- R8: A fault during the settle wait drops tmr_start_o on the same edge as pwr_good_o.
- R9: An input flag change affects the outputs on the (SYNC_STAGES+1)th rising edge after it; with the default value that is the third edge.
- R10: During bring-up, before power-good, no fault is checked. A low in33_ok_i in the I/O-rail wait changes nothing, and core_hold_ok_i is never used to advance the sequence.
- R11: After power-good, a low core_up_ok_i alone is not a fault. Only core_hold_ok_i checks the core rail.
- R12: For any order of flag changes and timer-done pulses, the outputs follow the sequence above cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in33_ok_i | input | 1 | 3.3 V input above 3.0 V |
| core_up_ok_i | input | 1 | 1.8 V rail above 1.7 V (bring-up) |
| core_hold_ok_i | input | 1 | 1.8 V rail above 1.71 V (fault check) |
| io_ok_i | input | 1 | 2.5 V rail above 2.375 V |
| tmr_done_i | input | 1 | Settle timer expired |
| core_ldo_en_o | output | 1 | 1.8 V regulator enable |
| io_conv_en_o | output | 1 | 2.5 V converter enable |
| cpu_rst_no | output | 1 | CPU reset, active low |
| pwr_good_o | output | 1 | All rails good |
| tmr_start_o | output | 1 | Settle timer run request |

## Verification
The bench uses the default SYNC_STAGES of 2 and derives its sampling points from that value. With that depth, a flag change shows at the outputs on the third edge, so the directed checks can pin the latency edge by edge and can place a fault exactly inside the settle wait or the run state. The random phase uses a two-deep flag pipeline in the bench model. This lets short flag glitches, which the synchronizer passes through unchanged, reach every state, including faults on the same edge as a timer-done pulse.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int unsigned FLAG_W       = 4;
  localparam int unsigned FL_IN        = 0;
  localparam int unsigned FL_CORE_UP   = 1;
  localparam int unsigned FL_CORE_HOLD = 2;
  localparam int unsigned FL_IO        = 3;

  typedef enum logic [2:0] {
    ST_WAIT_IN   = 3'd0,
    ST_WAIT_CORE = 3'd1,
    ST_WAIT_IO   = 3'd2,
    ST_SETTLE    = 3'd3,
    ST_RUN       = 3'd4,
    ST_SHED      = 3'd5,
    ST_HALT      = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic ldo_en;
    logic conv_en;
    logic rst_n;
    logic pg;
    logic start;
  } seq_out_t;

  localparam seq_out_t OUT_SAFE = '{ldo_en: 1'b0, conv_en: 1'b0, rst_n: 1'b0, pg: 1'b0, start: 1'b0};

  function automatic seq_out_t drive_of(seq_state_e st);
    seq_out_t o;
    o = OUT_SAFE;
    unique case (st)
      ST_WAIT_CORE: o.ldo_en = 1'b1;
      ST_WAIT_IO: begin o.ldo_en = 1'b1; o.conv_en = 1'b1; end
      ST_SETTLE: begin o.ldo_en = 1'b1; o.conv_en = 1'b1; o.pg = 1'b1; o.start = 1'b1; end
      ST_RUN: begin o.ldo_en = 1'b1; o.conv_en = 1'b1; o.pg = 1'b1; o.rst_n = 1'b1; end
      ST_SHED: begin o.ldo_en = 1'b1; o.conv_en = 1'b1; end
      default: o = OUT_SAFE;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/pwr_flag_sync.sv
module pwr_flag_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/pwr_fault_mon.sv
module pwr_fault_mon
  import pwr_seq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output logic              fault_o
);
  // core_up flag deliberately unused: fault check uses the tighter hold threshold
  always_comb begin
    fault_o = ~flags_i[FL_IN] | ~flags_i[FL_IO] | ~flags_i[FL_CORE_HOLD];
  end

  logic unused_core_up;
  assign unused_core_up = flags_i[FL_CORE_UP];
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              fault_i,
  input  logic              tmr_done_i,
  output logic              ldo_en_o,
  output logic              conv_en_o,
  output logic              cpu_rst_no,
  output logic              pg_o,
  output logic              start_o
);
  seq_state_e state_q, state_d;
  seq_out_t   out_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_IN:   if (flags_i[FL_IN])      state_d = ST_WAIT_CORE;
      ST_WAIT_CORE: if (flags_i[FL_CORE_UP]) state_d = ST_WAIT_IO;
      ST_WAIT_IO:   if (flags_i[FL_IO])      state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (fault_i)         state_d = ST_SHED;
        else if (tmr_done_i) state_d = ST_RUN;
      end
      ST_RUN:  if (fault_i) state_d = ST_SHED;
      ST_SHED: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_IN;
      out_q   <= OUT_SAFE;
    end else begin
      state_q <= state_d;
      out_q   <= drive_of(state_d);
    end
  end

  assign ldo_en_o   = out_q.ldo_en;
  assign conv_en_o  = out_q.conv_en;
  assign cpu_rst_no = out_q.rst_n;
  assign pg_o       = out_q.pg;
  assign start_o    = out_q.start;

  assert_conv_needs_ldo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_o |-> ldo_en_o);
  assert_pg_needs_rails_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_o |-> (ldo_en_o && conv_en_o));
  assert_rst_release_needs_pg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_no |-> pg_o);
  assert_fault_sheds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_o && fault_i) |=> (!pg_o && !cpu_rst_no && ldo_en_o && conv_en_o));
  assert_rails_off_after_shed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pg_o) |=> (!ldo_en_o && !conv_en_o));
  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ldo_en_o && $fell(conv_en_o)) |=> (!ldo_en_o && !conv_en_o && !pg_o));
  assert_start_in_settle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (pg_o && !cpu_rst_no));
endmodule

// File: rtl/power_seq_ctrl.sv
module power_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in33_ok_i,
  input  logic core_up_ok_i,
  input  logic core_hold_ok_i,
  input  logic io_ok_i,
  input  logic tmr_done_i,
  output logic core_ldo_en_o,
  output logic io_conv_en_o,
  output logic cpu_rst_no,
  output logic pwr_good_o,
  output logic tmr_start_o
);
  logic [FLAG_W-1:0] raw_flags, sync_flags;
  logic              fault;

  always_comb begin
    raw_flags               = '0;
    raw_flags[FL_IN]        = in33_ok_i;
    raw_flags[FL_CORE_UP]   = core_up_ok_i;
    raw_flags[FL_CORE_HOLD] = core_hold_ok_i;
    raw_flags[FL_IO]        = io_ok_i;
  end

  pwr_flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_flags),
    .q_o    (sync_flags)
  );

  pwr_fault_mon u_fault (
    .flags_i (sync_flags),
    .fault_o (fault)
  );

  pwr_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flags_i    (sync_flags),
    .fault_i    (fault),
    .tmr_done_i (tmr_done_i),
    .ldo_en_o   (core_ldo_en_o),
    .conv_en_o  (io_conv_en_o),
    .cpu_rst_no (cpu_rst_no),
    .pg_o       (pwr_good_o),
    .start_o    (tmr_start_o)
  );
endmodule

// File: tb/power_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module power_seq_ctrl_tb_top;
  localparam int unsigned STAGES = 2;
  localparam int unsigned LAT    = STAGES + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in33 = 1'b0, core_up = 1'b0, core_hold = 1'b0, io_ok = 1'b0, done = 1'b0;
  logic ldo_en, conv_en, rst_n, pg, start;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  power_seq_ctrl #(.SYNC_STAGES(STAGES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .in33_ok_i(in33), .core_up_ok_i(core_up), .core_hold_ok_i(core_hold),
    .io_ok_i(io_ok), .tmr_done_i(done),
    .core_ldo_en_o(ldo_en), .io_conv_en_o(conv_en), .cpu_rst_no(rst_n),
    .pwr_good_o(pg), .tmr_start_o(start)
  );

  // bench model: states 0 wait_in,1 wait_core,2 wait_io,3 settle,4 run,5 shed,6 halt
  logic [3:0] m_pipe [STAGES];
  int m_st;

  function automatic logic [4:0] exp_out(int st);
    case (st)
      1: return 5'b10000;
      2: return 5'b11000;
      3: return 5'b11011;
      4: return 5'b11110;
      5: return 5'b11000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic int next_st(int st, logic [3:0] f, logic d);
    logic flt;
    flt = !f[0] || !f[3] || !f[2];
    case (st)
      0: return f[0] ? 1 : 0;
      1: return f[1] ? 2 : 1;
      2: return f[3] ? 3 : 2;
      3: return flt ? 5 : (d ? 4 : 3);
      4: return flt ? 5 : 4;
      default: return 6;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) m_pipe[i] <= '0;
      m_st <= 0;
    end else begin
      m_pipe[0] <= {io_ok, core_hold, core_up, in33};
      for (int i = 1; i < STAGES; i++) m_pipe[i] <= m_pipe[i-1];
      m_st <= next_st(m_st, m_pipe[STAGES-1], done);
    end
  end

  function automatic logic [4:0] act();
    return {ldo_en, conv_en, rst_n, pg, start};
  endfunction

  task automatic chk(string tag, logic [4:0] exp);
    n_chk++;
    if (act() !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {ldo,conv,rst_n,pg,start} actual %b expected %b at %0t", tag, act(), exp, $time);
    end
  endtask

  // one edge, then sample 1 ns later; inputs set by caller afterwards
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    #1 rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
  endtask

  task automatic set_flags(logic a, logic b, logic c, logic d);
    in33 = a; core_up = b; core_hold = c; io_ok = d;
  endtask

  task automatic bring_to_settle();
    do_reset();
    set_flags(1, 1, 1, 1);
    tick(3 * LAT + 4);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds safe values even with all flags high
    set_flags(1, 1, 1, 1);
    done = 1'b1;
    tick(4);
    chk("R1 reset with inputs high", 5'b00000);
    done = 1'b0;
    set_flags(0, 0, 0, 0);
    rst_ni = 1'b1;
    tick(6);
    chk("R2 idle without input rail", 5'b00000);
    done = 1'b1; tick(1); done = 1'b0;
    chk("R5 done ignored outside settle", 5'b00000);
    tick(3);
    chk("R5 done ignored outside settle later", 5'b00000);
    // R9 latency
    in33 = 1'b1;
    tick(LAT - 1);
    chk("R9 no change before synchronizer latency", 5'b00000);
    tick(1);
    chk("R9/R2 ldo on, cpu reset held", 5'b10000);
    core_hold = 1'b1;
    tick(6);
    chk("R10 hold flag does not advance bring-up", 5'b10000);
    core_up = 1'b1;
    tick(LAT);
    chk("R3 converter enabled after core up", 5'b11000);
    in33 = 1'b0;
    tick(6);
    chk("R10 no fault check before power-good", 5'b11000);
    in33 = 1'b1;
    tick(LAT);
    io_ok = 1'b1;
    tick(LAT - 1);
    chk("R4 power-good not yet", 5'b11000);
    tick(1);
    chk("R4 power-good and timer start", 5'b11011);
    tick(5);
    chk("R4 start held during settle", 5'b11011);
    done = 1'b1; tick(1); done = 1'b0;
    chk("R5 reset released on timer done", 5'b11110);
    core_up = 1'b0;
    tick(6);
    chk("R11 core_up loss is not a fault", 5'b11110);
    io_ok = 1'b0;
    tick(LAT - 1);
    chk("R6 before fault seen", 5'b11110);
    tick(1);
    chk("R6 shed: pg low, cpu reset, enables on", 5'b11000);
    tick(1);
    chk("R7 rails off", 5'b00000);
    set_flags(1, 1, 1, 1);
    done = 1'b1;
    tick(10);
    done = 1'b0;
    chk("R7 halt is sticky", 5'b00000);

    // R8: fault during settle via hold flag
    bring_to_settle();
    chk("R4 settle reached", 5'b11011);
    core_hold = 1'b0;
    tick(LAT);
    chk("R8 start dropped with pg on fault in settle", 5'b11000);
    tick(1);
    chk("R7 rails off after settle fault", 5'b00000);

    // R6: input rail loss in run
    bring_to_settle();
    done = 1'b1; tick(1); done = 1'b0;
    in33 = 1'b0;
    tick(LAT);
    chk("R6 input rail fault in run", 5'b11000);
    tick(1);
    chk("R7 rails off after input fault", 5'b00000);

    // R12: random flag orderings against bench model
    for (int ep = 0; ep < 60; ep++) begin
      do_reset();
      set_flags(0, 0, 0, 0);
      for (int c = 0; c < 200; c++) begin
        logic [3:0] f;
        f = {io_ok, core_hold, core_up, in33};
        for (int b = 0; b < 4; b++) begin
          if (f[b]) begin
            if (($urandom % 40) == 0) f[b] = 1'b0;
          end else begin
            if (($urandom % 4) == 0) f[b] = 1'b1;
          end
        end
        {io_ok, core_hold, core_up, in33} = f;
        done = (($urandom % 7) == 0);
        tick(1);
        chk("R12 model compare", exp_out(m_st));
      end
      done = 1'b0;
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule